// File: doc/BRIEF.md
# Non-Maskable Interrupt Entry Sequencer

This block sits next to a small 32-bit processor core and owns the entry path of the non-maskable interrupt. It watches an asynchronous active-low interrupt pin. In normal running it reacts to a high-to-low transition and remembers it in a pending flag. While the core is halted in its low-power stop state, it reacts instead to the pin simply being low. The request is taken only when the level mask field of the current program status is above 15. The maskable-interrupt enable bit has no say in this.

The request is accepted when the core signals an instruction boundary. The sequencer then captures the core's context and takes over. It pushes the program status word and then the return address onto the system stack, one word at a time, through a write port that waits on a ready signal. In a final cycle it presents the values the core must load: the stack pointer lowered by 8, the status word with its level mask forced to 15 and its stack-select bit cleared, and a program counter equal to the table base plus 0x3C0.

Top module: `nmi_entry_seq`

## Requirements
- R1: Outside stop mode only a falling edge of `nmi_pin_n` raises a request. A pin that stays low after an entry has consumed its edge raises no new request.
- R2: While `stop_mode` is 1, a low level on `nmi_pin_n` raises a request with no edge needed. A high pin in stop mode raises none.
- R3: A request is accepted at an `insn_boundary` cycle only if the level mask `ps_in[20:16]` is greater than 15. A refused edge request stays pending and is taken at a later boundary once the mask allows it.
- R4: The interrupt-enable bit `ps_in[4]` has no effect on acceptance.
- R5: The first stack write goes to address SSP−4 and carries the status word captured at acceptance. The second goes to SSP−8 and carries the captured return address. Input changes after acceptance do not alter them.
- R6: While `mem_ready` is low, `mem_wr`, `mem_addr` and `mem_wdata` hold steady, and the sequencer does not advance.
- R7: When `entry_done` is high, `ssp_out` equals the captured SSP minus 8.
- R8: When `entry_done` is high, `ps_out` is the captured status word with bits [20:16] set to 15 and bit 5 (stack select) cleared. All other bits are unchanged.
- R9: When `entry_done` is high, `pc_out` equals the captured table base plus 0x3C0, wrapping modulo 2^32.
- R10: With `mem_ready` always high, `entry_done` is high in the third cycle after the accepting clock edge, which is within the 6-cycle bound. Each stalled write cycle adds exactly one cycle.
- R11: The pending edge flag clears when the status push starts. An edge that arrives during an entry sets it again, so a second entry follows at the next boundary.
- R12: After reset `busy`, `mem_wr` and `entry_done` are 0. `busy` is high from the accepting edge until `entry_done` has been shown for one cycle, and `entry_done` lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| stop_mode | input | 1 | Core is in stop mode (level detection) |
| insn_boundary | input | 1 | Core is at an instruction boundary this cycle |
| ps_in | input | 32 | Current program status (mask at [20:16], stack select at 5, enable at 4) |
| ssp_in | input | 32 | Current system stack pointer |
| next_pc_in | input | 32 | Address of the next instruction |
| tbr_in | input | 32 | Table base register |
| mem_ready | input | 1 | Stack write accepted this cycle |
| busy | output | 1 | Sequencer owns the core |
| mem_wr | output | 1 | Stack write request |
| mem_addr | output | 32 | Stack write address |
| mem_wdata | output | 32 | Stack write data |
| entry_done | output | 1 | One-cycle strobe: core loads the outputs below |
| ps_out | output | 32 | New program status |
| ssp_out | output | 32 | New system stack pointer |
| pc_out | output | 32 | Handler address |

## Verification
The assertions assume three things about the inputs. `mem_ready` is only acted on while a write is requested. `ps_in` is valid in every cycle where `insn_boundary` is high. The pin holds each level long enough for the two-flop synchronizer to see it. The stimulus follows these assumptions: it changes every input at the falling clock edge and holds each pin level for at least four cycles. It raises `mem_ready` only during a write, after a chosen number of stall cycles.

// File: rtl/nmi_entry_pkg.sv
package nmi_entry_pkg;
    localparam int XLEN        = 32;
    localparam int ILM_W       = 5;
    localparam int ILM_LSB     = 16;
    localparam int S_BIT       = 5;
    localparam int ILM_ENTRY   = 15;
    localparam int ILM_THRESH  = 15;
    localparam int WORD_BYTES  = XLEN / 8;
    localparam logic [XLEN-1:0] WORD_STEP  = XLEN'(WORD_BYTES);
    localparam logic [XLEN-1:0] FRAME_STEP = XLEN'(2 * WORD_BYTES);

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH_PS,
        ST_PUSH_PC,
        ST_DONE
    } entry_state_t;

    typedef struct packed {
        word_t ps;
        word_t ssp;
        word_t ret_pc;
        word_t tbr;
    } entry_ctx_t;

    function automatic logic [ILM_W-1:0] ps_level(input word_t ps);
        return ps[ILM_LSB +: ILM_W];
    endfunction

    function automatic word_t ps_on_entry(input word_t ps);
        word_t r;
        r = ps;
        r[ILM_LSB +: ILM_W] = ILM_W'(ILM_ENTRY);
        r[S_BIT] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/nmi_pin_detect.sv
module nmi_pin_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic stop_mode,
    input  logic clear_pend,
    output logic pin_low,
    output logic pend
);
    logic [STAGES:0] chain;
    logic            synced;
    logic            prev;
    logic            fall;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], pin_n};
    end

    assign synced  = chain[STAGES-1];
    assign prev    = chain[STAGES];
    assign fall    = prev & ~synced;
    assign pin_low = ~synced;

    // a new edge wins over the clear so it is not lost during entry
    always_ff @(posedge clk) begin
        if (rst)                     pend <= 1'b0;
        else if (fall && !stop_mode) pend <= 1'b1;
        else if (clear_pend)         pend <= 1'b0;
    end
endmodule

// File: rtl/nmi_accept_gate.sv
module nmi_accept_gate
    import nmi_entry_pkg::*;
(
    input  logic  idle,
    input  logic  boundary,
    input  logic  pend,
    input  logic  stop_mode,
    input  logic  pin_low,
    input  word_t ps,
    output logic  accept
);
    logic req;
    logic level_ok;

    assign req      = pend | (stop_mode & pin_low);
    assign level_ok = ps_level(ps) > ILM_W'(ILM_THRESH);
    assign accept   = idle & boundary & req & level_ok;
endmodule

// File: rtl/nmi_entry_fsm.sv
module nmi_entry_fsm
    import nmi_entry_pkg::*;
#(
    parameter logic [31:0] VEC_OFFSET = 32'h0000_03C0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  entry_ctx_t ctx_in,
    input  logic       mem_ready,
    output logic       busy,
    output logic       mem_wr,
    output word_t      mem_addr,
    output word_t      mem_wdata,
    output logic       done,
    output word_t      ps_out,
    output word_t      ssp_out,
    output word_t      pc_out
);
    entry_state_t state;
    entry_ctx_t   ctx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ctx   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    ctx   <= ctx_in;
                    state <= ST_PUSH_PS;
                end
                ST_PUSH_PS: if (mem_ready) state <= ST_PUSH_PC;
                ST_PUSH_PC: if (mem_ready) state <= ST_DONE;
                ST_DONE:    state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (state == ST_PUSH_PS) begin
            mem_wr    = 1'b1;
            mem_addr  = ctx.ssp - WORD_STEP;
            mem_wdata = ctx.ps;
        end else if (state == ST_PUSH_PC) begin
            mem_wr    = 1'b1;
            mem_addr  = ctx.ssp - FRAME_STEP;
            mem_wdata = ctx.ret_pc;
        end
    end

    assign busy    = state != ST_IDLE;
    assign done    = state == ST_DONE;
    assign ps_out  = ps_on_entry(ctx.ps);
    assign ssp_out = ctx.ssp - FRAME_STEP;
    assign pc_out  = ctx.tbr + VEC_OFFSET;
endmodule

// File: rtl/nmi_entry_seq.sv
module nmi_entry_seq
    import nmi_entry_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] VEC_OFFSET  = 32'h0000_03C0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        nmi_pin_n,
    input  logic        stop_mode,
    input  logic        insn_boundary,
    input  logic [31:0] ps_in,
    input  logic [31:0] ssp_in,
    input  logic [31:0] next_pc_in,
    input  logic [31:0] tbr_in,
    input  logic        mem_ready,
    output logic        busy,
    output logic        mem_wr,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        entry_done,
    output logic [31:0] ps_out,
    output logic [31:0] ssp_out,
    output logic [31:0] pc_out
);
    logic       pin_low;
    logic       pend;
    logic       accept;
    entry_ctx_t ctx_in;

    assign ctx_in = '{ps: ps_in, ssp: ssp_in, ret_pc: next_pc_in, tbr: tbr_in};

    nmi_pin_detect #(.STAGES(SYNC_STAGES)) u_detect (
        .clk        (clk),
        .rst        (rst),
        .pin_n      (nmi_pin_n),
        .stop_mode  (stop_mode),
        .clear_pend (accept),
        .pin_low    (pin_low),
        .pend       (pend)
    );

    nmi_accept_gate u_gate (
        .idle      (~busy),
        .boundary  (insn_boundary),
        .pend      (pend),
        .stop_mode (stop_mode),
        .pin_low   (pin_low),
        .ps        (ps_in),
        .accept    (accept)
    );

    nmi_entry_fsm #(.VEC_OFFSET(VEC_OFFSET)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .ctx_in    (ctx_in),
        .mem_ready (mem_ready),
        .busy      (busy),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (entry_done),
        .ps_out    (ps_out),
        .ssp_out   (ssp_out),
        .pc_out    (pc_out)
    );
endmodule

// File: rtl/nmi_entry_chk.sv
module nmi_entry_chk
    import nmi_entry_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        insn_boundary,
    input logic [31:0] ps_in,
    input logic        mem_ready,
    input logic        busy,
    input logic        mem_wr,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        entry_done,
    input logic [31:0] ps_out,
    input logic [31:0] ssp_out
);
    logic [31:0] last_ack_addr;

    always_ff @(posedge clk) begin
        if (rst)                    last_ack_addr <= '0;
        else if (mem_wr && mem_ready) last_ack_addr <= mem_addr;
    end

    p_hold_write_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    p_masked_stays_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && insn_boundary && ps_level(ps_in) <= ILM_W'(ILM_THRESH)) |=> !busy);

    p_accept_needs_level_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(insn_boundary) && ps_level($past(ps_in)) > ILM_W'(ILM_THRESH)));

    p_stack_drop_r7: assert property (@(posedge clk) disable iff (rst)
        entry_done |-> (ssp_out == last_ack_addr));

    p_status_update_r8: assert property (@(posedge clk) disable iff (rst)
        entry_done |-> (ps_level(ps_out) == ILM_W'(ILM_ENTRY) && !ps_out[S_BIT]));

    p_single_done_r12: assert property (@(posedge clk) disable iff (rst)
        entry_done |=> !entry_done);

    p_done_no_write_r12: assert property (@(posedge clk) disable iff (rst)
        entry_done |-> (busy && !mem_wr));
endmodule

bind nmi_entry_seq nmi_entry_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .insn_boundary (insn_boundary),
    .ps_in         (ps_in),
    .mem_ready     (mem_ready),
    .busy          (busy),
    .mem_wr        (mem_wr),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .entry_done    (entry_done),
    .ps_out        (ps_out),
    .ssp_out       (ssp_out)
);

// File: tb/tb_nmi_entry_seq.sv
`timescale 1ns/1ps
module tb_nmi_entry_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        nmi_pin_n;
    logic        stop_mode;
    logic        insn_boundary;
    logic [31:0] ps_in, ssp_in, next_pc_in, tbr_in;
    logic        mem_ready;
    logic        busy, mem_wr, entry_done;
    logic [31:0] mem_addr, mem_wdata, ps_out, ssp_out, pc_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    nmi_entry_seq dut (
        .clk(clk), .rst(rst), .nmi_pin_n(nmi_pin_n), .stop_mode(stop_mode),
        .insn_boundary(insn_boundary), .ps_in(ps_in), .ssp_in(ssp_in),
        .next_pc_in(next_pc_in), .tbr_in(tbr_in), .mem_ready(mem_ready),
        .busy(busy), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .entry_done(entry_done), .ps_out(ps_out), .ssp_out(ssp_out), .pc_out(pc_out)
    );

    typedef struct packed {
        logic        stop;
        logic        pin_low;
        logic [4:0]  ilm;
        logic        ien;
        logic [31:0] ssp;
        logic [31:0] npc;
        logic [31:0] tbr;
        logic [3:0]  st_ps;
        logic [3:0]  st_pc;
        logic        acc;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 5'd31, 1'b0, 32'h0000_1000, 32'h0000_0200, 32'h0000_8000, 4'd0, 4'd0, 1'b1},
        '{1'b0, 1'b1, 5'd16, 1'b1, 32'h0002_0040, 32'h0000_1234, 32'h0001_0000, 4'd2, 4'd1, 1'b1},
        '{1'b0, 1'b1, 5'd15, 1'b0, 32'h0000_2000, 32'h0000_0300, 32'h0000_8000, 4'd0, 4'd0, 1'b0},
        '{1'b0, 1'b0, 5'd31, 1'b0, 32'h0000_2000, 32'h0000_0300, 32'h0000_8000, 4'd0, 4'd0, 1'b0},
        '{1'b1, 1'b1, 5'd20, 1'b0, 32'h0000_3008, 32'h00AB_CDE0, 32'h0004_0000, 4'd0, 4'd3, 1'b1},
        '{1'b1, 1'b0, 5'd31, 1'b1, 32'h0000_3008, 32'h0000_0400, 32'h0004_0000, 4'd0, 4'd0, 1'b0},
        '{1'b0, 1'b1, 5'd0,  1'b1, 32'h0000_4000, 32'h0000_0500, 32'h0000_8000, 4'd0, 4'd0, 1'b0},
        '{1'b0, 1'b1, 5'd17, 1'b1, 32'h0000_0008, 32'hFFFF_FFF0, 32'hFFFF_FC80, 4'd1, 4'd2, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkps(input logic [4:0] ilm, input logic ien);
        return 32'hA000_0A20 | ({27'd0, ilm} << 16) | ({31'd0, ien} << 4);
    endfunction

    function automatic logic [31:0] ps_expect(input logic [31:0] ps);
        return (ps & ~(32'h1F << 16) & ~32'h20) | (32'd15 << 16);
    endfunction

    task automatic do_reset();
        rst = 1'b1; nmi_pin_n = 1'b1; stop_mode = 1'b0; insn_boundary = 1'b0;
        ps_in = '0; ssp_in = '0; next_pc_in = '0; tbr_in = '0; mem_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_pin(input logic v);
        nmi_pin_n = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_none(input string tag, input logic [31:0] ps);
        ps_in = ps; ssp_in = 32'h100; next_pc_in = 32'h40; tbr_in = 32'h0;
        insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0;
        chk({tag, " busy"}, {31'd0, busy}, 32'd0);
        chk({tag, " mem_wr"}, {31'd0, mem_wr}, 32'd0);
        @(negedge clk);
        chk({tag, " still idle"}, {31'd0, busy}, 32'd0);
    endtask

    task automatic expect_entry(input logic [31:0] ps, ssp, npc, tbr,
                                input int sps, input int spc, input bit drop_mid);
        int cyc;
        ps_in = ps; ssp_in = ssp; next_pc_in = npc; tbr_in = tbr;
        mem_ready = 1'b0; insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0;
        cyc = 1;
        ps_in = ~ps; ssp_in = ~ssp; next_pc_in = ~npc; tbr_in = ~tbr;
        chk("R12 busy after accept", {31'd0, busy}, 32'd1);
        chk("R5 first write req", {31'd0, mem_wr}, 32'd1);
        chk("R5 status addr", mem_addr, ssp - 32'd4);
        chk("R5 status data", mem_wdata, ps);
        for (int k = 0; k < sps; k++) begin
            if (drop_mid && k == 0) nmi_pin_n = 1'b0;
            @(negedge clk);
            cyc++;
            chk("R6 status write held", {31'd0, mem_wr}, 32'd1);
            chk("R6 status addr held", mem_addr, ssp - 32'd4);
            chk("R6 status data held", mem_wdata, ps);
        end
        mem_ready = 1'b1;
        @(negedge clk);
        cyc++;
        mem_ready = 1'b0;
        chk("R5 return addr", mem_addr, ssp - 32'd8);
        chk("R5 return data", mem_wdata, npc);
        for (int k = 0; k < spc; k++) begin
            @(negedge clk);
            cyc++;
            chk("R6 return addr held", mem_addr, ssp - 32'd8);
            chk("R6 no done while stalled", {31'd0, entry_done}, 32'd0);
        end
        mem_ready = 1'b1;
        @(negedge clk);
        cyc++;
        mem_ready = 1'b0;
        chk("R10 done on time", {31'd0, entry_done}, 32'd1);
        chk("R10 cycle count", cyc, 3 + sps + spc);
        chk("R10 within bound", {31'd0, cyc <= 6 + sps + spc}, 32'd1);
        chk("R7 stack pointer", ssp_out, ssp - 32'd8);
        chk("R8 status out", ps_out, ps_expect(ps));
        chk("R9 handler address", pc_out, tbr + 32'h3C0);
        chk("R12 no write in done", {31'd0, mem_wr}, 32'd0);
        @(negedge clk);
        chk("R12 done one cycle", {31'd0, entry_done}, 32'd0);
        chk("R12 busy released", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        chk("R12 reset busy", {31'd0, busy}, 32'd0);
        chk("R12 reset mem_wr", {31'd0, mem_wr}, 32'd0);
        chk("R12 reset done", {31'd0, entry_done}, 32'd0);

        // vector table: R1 R2 R3 R4 and entry outputs
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VECS[i];
            do_reset();
            stop_mode = v.stop;
            if (v.pin_low) set_pin(1'b0);
            if (v.acc)
                expect_entry(mkps(v.ilm, v.ien), v.ssp, v.npc, v.tbr,
                             int'(v.st_ps), int'(v.st_pc), 1'b0);
            else
                expect_none("R1 R2 R3 R4 vector refused", mkps(v.ilm, v.ien));
            stop_mode = 1'b0;
            set_pin(1'b1);
        end

        // R3: refused edge stays pending and is taken later
        do_reset();
        set_pin(1'b0);
        expect_none("R3 masked at 15", mkps(5'd15, 1'b1));
        expect_entry(mkps(5'd31, 1'b0), 32'h0000_5000, 32'h0000_0600, 32'h0000_0000, 0, 0, 1'b0);

        // R1: low pin with consumed edge raises nothing more
        expect_none("R1 held low no request", mkps(5'd31, 1'b0));

        // R11: edge during entry re-arms a second entry
        set_pin(1'b1);
        set_pin(1'b0);
        set_pin(1'b1);
        expect_entry(mkps(5'd31, 1'b0), 32'h0000_6000, 32'h0000_0700, 32'h0000_2000, 5, 0, 1'b1);
        expect_entry(mkps(5'd18, 1'b1), 32'h0000_7000, 32'h0000_0800, 32'h0000_3000, 0, 0, 1'b0);
        expect_none("R11 pending cleared after second", mkps(5'd31, 1'b0));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule